// File: doc/BRIEF.md
# Register-Selected DDS Channel

This block is one digital synthesis channel whose frequency and phase are set per instruction. Two banks of sixteen registers, a tuning-word bank and a phase-offset bank, are loaded through a simple write port. On every instruction a 4-bit frequency index and a 4-bit phase index pick one register from each bank. A 32-bit phase accumulator advances by the chosen tuning word on every clock.

The accumulator plus the left-aligned phase offset addresses a 1024-entry cosine table computed at elaboration. The table gives a 14-bit signed, registered amplitude sample. A transmit-enable line gates the sample to zero without stopping the accumulator. A phase-reset line clears the accumulator and holds it at zero for as long as it is high. While it is high, the output shows only the selected phase offset. Pulses therefore start phase-aligned from scan to scan. With a quarter-turn offset selected, the held output sits at the midpoint level (zero).

Top module: `dds_chan_ctrl`

## Requirements
- R1: While rst_n is low, sample_out is 0. Reset clears the accumulator and every register of both banks to 0.
- R2: When wr_en is high at a clock edge, wr_bank=0 stores wr_data[31:0] into tuning register wr_addr, and wr_bank=1 stores wr_data[11:0] into phase register wr_addr. When wr_en is low, no register changes.
- R3: With phase_rst low, each clock adds the selected tuning word to the 32-bit accumulator, modulo 2^32.
- R4: The 12-bit phase offset is placed on accumulator bits 31:20 and added modulo 2^32. Bits 31:22 of that sum form the table address.
- R5: One clock after an edge, sample_out equals round(8191*cos(2*pi*a/1024)), where a is the address formed before that edge. Rounding is half away from zero.
- R6: When tx_en is low at an edge, sample_out is 0 after that edge. The accumulator keeps advancing.
- R7: When phase_rst is high at an edge, the accumulator becomes 0 and the sample uses an accumulator value of 0. Offset 0 gives 8191, and offset 12'h400 (90 degrees) gives 0.
- R8: A change of freq_sel or phase_sel takes effect at the next edge, without clearing the accumulator.
- R9: Each bank holds 16 registers. freq_sel and phase_sel (4 bits each) index their banks independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 1 | Bank to write: 0 tuning, 1 phase |
| wr_addr | input | 4 | Register index to write |
| wr_data | input | 32 | Write data; phase bank uses bits 11:0 |
| freq_sel | input | 4 | Tuning register index for this instruction |
| phase_sel | input | 4 | Phase register index for this instruction |
| tx_en | input | 1 | Output enable; low forces sample to 0 |
| phase_rst | input | 1 | Hold accumulator at time zero |
| sample_out | output | 14 | Signed amplitude sample |

## Verification
The bench goes after held phase reset with offsets 0 and a quarter turn. A design that kept counting, or that registered the reset one cycle late, would show a moving or wrong sample instead of 8191 and 0. It runs tuning words near 2^32 to catch an accumulator that saturates instead of wrapping. It also gates tx_en off mid-run and then back on. A design that froze the accumulator while gated would come back at the wrong phase. Writes with wr_en low and select changes on every instruction are checked too. They expose a bank that takes stray writes, and a select path that resets the accumulator or lags by an extra cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int ACC_W  = 32;
  localparam int BANK_N = 16;
  localparam int PH_W   = 12;
  localparam int LUT_AW = 10;
  localparam int AMP_W  = 14;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded cosine sample at table index idx for a table of 2**aw entries.
  function automatic logic signed [AMP_W-1:0] cos_point(int idx, int aw);
    real v;
    real peak;
    peak = real'((1 << (AMP_W - 1)) - 1);
    v = peak * $cos(TWO_PI * real'(idx) / real'(1 << aw));
    if (v >= 0.0) v = v + 0.5;
    else          v = v - 0.5;
    return AMP_W'($rtoi(v));
  endfunction
endpackage

// File: rtl/dds_reg_bank.sv
module dds_reg_bank #(
  parameter int N = 16,
  parameter int W = 32,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] regs_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic         ld;
    logic [W-1:0] nxt;

    always_comb begin
      ld  = wr_en && (wr_addr == SW'(i));
      nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[i] <= '0;
      else if (ld) regs_q[i] <= nxt;
    end
  end

  assign rd_data = regs_q[rd_sel];
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    if (clr) acc_d = '0;
    else     acc_d = acc + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end
endmodule

// File: rtl/dds_wave_lut.sv
module dds_wave_lut
  import dds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AW    = 10,
  parameter int DW    = 14,
  localparam int DEPTH = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ACC_W-1:0]     phase,
  input  logic [PH_W-1:0]      offset,
  input  logic                 gate,
  output logic signed [DW-1:0] sample
);
  logic signed [DW-1:0] tab [DEPTH];
  logic [ACC_W-1:0]     sum;
  logic [AW-1:0]        addr;
  logic signed [DW-1:0] sample_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    assign tab[i] = DW'(cos_point(i, AW));
  end

  always_comb begin
    sum      = phase + {offset, {(ACC_W-PH_W){1'b0}}};
    addr     = sum[ACC_W-1 -: AW];
    sample_d = gate ? tab[addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample <= '0;
    else        sample <= sample_d;
  end
endmodule

// File: rtl/dds_chan_ctrl.sv
module dds_chan_ctrl
  import dds_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_bank,
  input  logic [3:0]              wr_addr,
  input  logic [ACC_W-1:0]        wr_data,
  input  logic [3:0]              freq_sel,
  input  logic [3:0]              phase_sel,
  input  logic                    tx_en,
  input  logic                    phase_rst,
  output logic signed [AMP_W-1:0] sample_out
);
  logic             wr_freq, wr_phase;
  logic [ACC_W-1:0] tune_word;
  logic [PH_W-1:0]  phase_word;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_eff;

  always_comb begin
    wr_freq  = wr_en && !wr_bank;
    wr_phase = wr_en &&  wr_bank;
    acc_eff  = phase_rst ? '0 : acc_q;
  end

  dds_reg_bank #(.N(BANK_N), .W(ACC_W)) u_freq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_freq), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(freq_sel), .rd_data(tune_word)
  );

  dds_reg_bank #(.N(BANK_N), .W(PH_W)) u_phase_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_phase), .wr_addr(wr_addr),
    .wr_data(wr_data[PH_W-1:0]), .rd_sel(phase_sel), .rd_data(phase_word)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(phase_rst), .step(tune_word), .acc(acc_q)
  );

  dds_wave_lut #(.ACC_W(ACC_W), .PH_W(PH_W), .AW(LUT_AW), .DW(AMP_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .phase(acc_eff), .offset(phase_word),
    .gate(tx_en), .sample(sample_out)
  );
endmodule

// File: rtl/dds_chan_ctrl_chk.sv
module dds_chan_ctrl_chk
  import dds_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [3:0]              freq_sel,
  input logic                    tx_en,
  input logic                    phase_rst,
  input logic [ACC_W-1:0]        acc_q,
  input logic [ACC_W-1:0]        tune_word,
  input logic [PH_W-1:0]         phase_word,
  input logic signed [AMP_W-1:0] sample_out
);
  localparam logic signed [AMP_W-1:0] PEAK = AMP_W'((1 << (AMP_W-1)) - 1);

  p_gate_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> sample_out == '0);

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> acc_q == '0);

  p_quarter_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_rst && tx_en && phase_word == 12'h400) |=> sample_out == '0);

  p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_rst |=> acc_q == $past(acc_q) + $past(tune_word));

  p_sel_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(freq_sel) && !phase_rst) |=> acc_q == $past(acc_q) + $past(tune_word));

  p_amp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out <= PEAK) && (sample_out >= -PEAK));
endmodule

bind dds_chan_ctrl dds_chan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .tx_en(tx_en),
  .phase_rst(phase_rst), .acc_q(acc_q), .tune_word(tune_word),
  .phase_word(phase_word), .sample_out(sample_out)
);

// File: tb/sim_dds_chan_ctrl.sv
module sim_dds_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;
  localparam int WATCHDOG   = 100000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en, wr_bank;
  logic [3:0]         wr_addr;
  logic [31:0]        wr_data;
  logic [3:0]         freq_sel, phase_sel;
  logic               tx_en, phase_rst;
  logic signed [13:0] sample_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_tune [16];
  logic [11:0] m_ph   [16];
  logic [31:0] m_acc;
  logic signed [13:0] m_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .freq_sel(freq_sel),
    .phase_sel(phase_sel), .tx_en(tx_en), .phase_rst(phase_rst),
    .sample_out(sample_out)
  );

  function automatic logic signed [13:0] ref_cos(logic [9:0] a);
    real v;
    v = 8191.0 * $cos(6.283185307179586 * real'(a) / 1024.0);
    v = (v >= 0.0) ? v + 0.5 : v - 0.5;
    return 14'($rtoi(v));
  endfunction

  task automatic check(string tag, logic signed [13:0] act, logic signed [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sample_out=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: model the edge from requirements, then compare at the falling edge.
  task automatic cycle(string tag);
    logic [31:0] a;
    logic [31:0] s;
    @(posedge clk);
    a = phase_rst ? 32'd0 : m_acc;
    s = a + {m_ph[phase_sel], 20'd0};           // R4
    m_exp = tx_en ? ref_cos(s[31:22]) : 14'sd0; // R5, R6
    m_acc = phase_rst ? 32'd0 : m_acc + m_tune[freq_sel]; // R3, R7, R8
    if (wr_en) begin                            // R2, R9
      if (wr_bank) m_ph[wr_addr] = wr_data[11:0];
      else         m_tune[wr_addr] = wr_data;
    end
    @(negedge clk);
    check(tag, sample_out, m_exp);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_bank = 0; wr_addr = 0; wr_data = 0;
    freq_sel = 0; phase_sel = 0; tx_en = 0; phase_rst = 0;
  endtask

  task automatic wr(bit bank, logic [3:0] ad, logic [31:0] d, string tag);
    wr_en = 1; wr_bank = bank; wr_addr = ad; wr_data = d;
    cycle(tag);
    wr_en = 0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] ps, fs;
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    idle_inputs();
    rst_n = 0;
    m_acc = 0;
    for (int i = 0; i < 16; i++) begin m_tune[i] = 0; m_ph[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset", sample_out, 14'sd0);
    tx_en = 1;
    @(negedge clk);
    check("R1 reset held", sample_out, 14'sd0);
    rst_n = 1;
    cycle("R1 zero regs");  // all-zero banks: cos(0) = 8191
    check("R1 zero regs value", m_exp, 14'sd8191);

    // R2/R9: fill both banks, entries distinct
    for (int i = 0; i < 16; i++) wr(0, 4'(i), 32'h0100_0000 * (i + 1) + 32'(i), "R2 tune write");
    for (int i = 0; i < 16; i++) wr(1, 4'(i), 32'hABC0_0000 | 32'(i * 64), "R2 phase write");

    // R2: write strobe low is ignored
    wr_en = 0; wr_bank = 1; wr_addr = 4'd3; wr_data = 32'h0000_0400;
    phase_sel = 4'd3; phase_rst = 1;
    cycle("R2 ignored write");
    wr_bank = 0; wr_data = 32'h0;

    // R7: held reset, offset 0 gives peak, quarter turn gives midpoint
    wr(1, 4'd0, 32'h0, "R2 phase0");
    wr(1, 4'd1, 32'h400, "R2 phase90");
    phase_rst = 1; phase_sel = 4'd0; freq_sel = 4'd5;
    repeat (3) begin
      cycle("R7 hold offset 0");
      check("R7 peak value", sample_out, 14'sd8191);
    end
    phase_sel = 4'd1;
    repeat (3) begin
      cycle("R7 hold 90 deg");
      check("R7 midpoint", sample_out, 14'sd0);
    end
    phase_rst = 0;
    repeat (4) cycle("R7 release");

    // R3: wrap near 2^32
    wr(0, 4'd15, 32'hFFFF_FFF0, "R2 big tune");
    freq_sel = 4'd15; phase_sel = 4'd0;
    repeat (20) cycle("R3 wrap");

    // R6: gate off while running, then back on
    tx_en = 0;
    repeat (5) begin
      cycle("R6 gated");
      check("R6 zero", sample_out, 14'sd0);
    end
    tx_en = 1;
    repeat (5) cycle("R6 ungated phase kept");

    // R8: select changes every instruction
    for (int i = 0; i < 32; i++) begin
      freq_sel = 4'(i); phase_sel = 4'(15 - i);
      cycle("R8 select change");
    end

    // Random mix
    for (int i = 0; i < N_RAND; i++) begin
      fs = 4'($urandom_range(0, 15));
      ps = 4'($urandom_range(0, 15));
      freq_sel = fs; phase_sel = ps;
      tx_en     = ($urandom_range(0, 7) != 0);
      phase_rst = ($urandom_range(0, 15) == 0);
      wr_en     = ($urandom_range(0, 9) == 0);
      wr_bank   = 1'($urandom_range(0, 1));
      wr_addr   = 4'($urandom_range(0, 15));
      wr_data   = $urandom;
      if (phase_rst)  cycle("R7 random");
      else if (!tx_en) cycle("R6 random");
      else             cycle("R5 random");
    end
    idle_inputs();

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule